// File: doc/BRIEF.md
# Coarse Tick Delay with Marker Capture

Each receive channel, once its sampling phase is fixed, needs a whole-tick latency correction so that all channels of a system present the same bunch crossing in the same cycle. This block delays the incoming data word by a programmable number of ticks, from zero to three. It also captures eight consecutive delayed words into a small local buffer when a start strobe arrives. The strobe is broadcast to every channel in the same cycle, so the buffers of different channels can be compared directly.

The input carries a repeating eight-tick pattern in which one tick per period has the marker bit set. The block reports where the marker fell among the eight captured ticks, and software reads the buffer through an address port. From the reported positions, software works out the extra delay each channel needs. The delay must be written again every time the sampling phase is chosen anew. A parameter chooses between a full-word buffer and a reduced buffer that keeps only the marker bit.

Top module: `tick_align_spy`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `out_word`, `spy_done`, `mark_valid` and `rd_data` are all zero, and the delay setting is 0.
- R2: `out_word` equals the `in_word` value sampled D+1 rising edges earlier, where D (0 to 3) is the current delay setting.
- R3: A write (`dly_we` high) loads `dly_wdata` at that edge. The new tap drives `out_word` from the following cycle on.
- R4: When `arm` is high at an edge, the `out_word` values of the next eight cycles are stored at buffer indices 0 to 7, in order.
- R5: `spy_done` rises at the edge that stores index 7. It stays high until the next `arm`, which clears it at the edge where `arm` is sampled.
- R6: With the reduced buffer (`FULL_SPY`=0), each entry is the single bit 4 of the captured word, and `rd_data` is one bit wide.
- R7: Once done with exactly one captured word that has bit 4 set, `mark_valid` is high and `mark_pos` holds that word's index.
- R8: If none, or two or more, of the eight captured words have bit 4 set, `mark_valid` stays low after done.
- R9: `rd_data` shows the buffer entry at the `rd_addr` sampled on the previous edge. A write at that same edge is not yet visible.
- R10: After done and before the next `arm`, input data does not change the buffer contents.
- R11: An `arm` during a capture restarts it at index 0, and clears the marker state and the done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_word | input | DATA_W | Phase-aligned input word |
| dly_we | input | 1 | Delay setting write strobe |
| dly_wdata | input | DLY_W | New delay in ticks |
| arm | input | 1 | Broadcast capture start strobe |
| rd_addr | input | IDX_W | Buffer read index |
| out_word | output | DATA_W | Delayed data word |
| rd_data | output | SPY_W | Buffer entry, one cycle after address |
| spy_done | output | 1 | Eight ticks captured |
| mark_pos | output | IDX_W | Index of first marker tick |
| mark_valid | output | 1 | Exactly one marker captured |

## Verification
A wrong tap or a stale shift stage shows on `out_word` within four cycles of the input changing. The reference compares that word every cycle, so the error is caught at once. A wrong capture counter or an early stop shows as a misplaced buffer entry, or as `spy_done` rising in the wrong cycle. Both appear nine cycles after `arm`, and the continuous sweep of `rd_addr` reads every index within the next eight cycles. Errors in marker counting show on `mark_valid` and `mark_pos` as soon as done rises. Errors in the hold-after-done state show as buffer entries changing while no `arm` is given.

// File: rtl/tas_pkg.sv
// Shared types for the tick alignment block.
// Assumes: nothing beyond IEEE 1800-2017.
package tas_pkg;
    typedef enum logic [1:0] {
        SPY_IDLE = 2'd0,
        SPY_RUN  = 2'd1,
        SPY_DONE = 2'd2
    } spy_state_t;
endpackage

// File: rtl/tas_delay_line.sv
// Fixed-length shift register with a tap selector.
// Tap k is the input delayed by k+1 edges.
// Assumes: sel never exceeds DEPTH-1.
module tas_delay_line #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic [SEL_W-1:0]  sel,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] stage [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            // Shift one stage per tick, cleared in reset.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage[g] <= '0;
                else if (g == 0)
                    stage[g] <= din;
                else
                    stage[g] <= stage[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    // Select the tap for the current delay setting.
    assign dout = stage[sel];
endmodule

// File: rtl/tas_spy_ctrl.sv
// Capture sequencer: starts on arm, writes DEPTH entries, then holds in done.
// Assumes: arm is a single-cycle broadcast strobe, though longer pulses simply restart.
module tas_spy_ctrl
    import tas_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             running,
    output logic             done
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    spy_state_t state;

    // Sequence the capture; arm has priority in every state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SPY_IDLE;
            wr_idx <= '0;
        end else if (arm) begin
            state  <= SPY_RUN;
            wr_idx <= '0;
        end else if (state == SPY_RUN) begin
            wr_idx <= wr_idx + 1'b1;
            if (wr_idx == LAST)
                state <= SPY_DONE;
        end
    end

    // Decode the state into the strobes the buffer and tracker use.
    always_comb begin
        running = (state == SPY_RUN);
        done    = (state == SPY_DONE);
        wr_en   = running && !arm;
    end
endmodule

// File: rtl/tas_spy_mem.sv
// Small capture buffer with a registered read port.
// Assumes: DEPTH is small, so entries are cleared in reset.
module tas_spy_mem #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [W-1:0]     wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [W-1:0]     rd_data
);
    logic [W-1:0] mem [DEPTH];

    // Store captured entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    // Read with one cycle of latency, returning the old contents on a same-edge write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data <= '0;
        else
            rd_data <= mem[rd_idx];
    end
endmodule

// File: rtl/tas_marker_track.sv
// Counts marker hits during a capture and keeps the index of the first one.
// Assumes: clr and hit are never high together (the sequencer gates writes on arm).
module tas_marker_track #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             hit,
    input  logic [IDX_W-1:0] idx,
    input  logic             done,
    output logic [IDX_W-1:0] first_idx,
    output logic             single
);
    logic [1:0] hits;

    // Track the first marker index and a saturating hit count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hits      <= '0;
            first_idx <= '0;
        end else if (hit) begin
            if (hits == 2'd0)
                first_idx <= idx;
            if (hits != 2'd2)
                hits <= hits + 2'd1;
        end
    end

    // Result is valid only after capture and with exactly one marker.
    assign single = done && (hits == 2'd1);
endmodule

// File: rtl/tick_align_spy.sv
// Per-channel coarse tick delay (0..MAX_DLY) with an armed capture of the delayed stream.
// Assumes: the sampling phase is fixed upstream; arm reaches all channels in the same cycle.
module tick_align_spy #(
    parameter int DATA_W    = 8,
    parameter int MARK_BIT  = 4,
    parameter int MAX_DLY   = 3,
    parameter int SPY_DEPTH = 8,
    parameter int FULL_SPY  = 1,
    parameter int DLY_W     = $clog2(MAX_DLY + 1),
    parameter int IDX_W     = $clog2(SPY_DEPTH),
    parameter int SPY_W     = (FULL_SPY != 0) ? DATA_W : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_word,
    input  logic              dly_we,
    input  logic [DLY_W-1:0]  dly_wdata,
    input  logic              arm,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] out_word,
    output logic [SPY_W-1:0]  rd_data,
    output logic              spy_done,
    output logic [IDX_W-1:0]  mark_pos,
    output logic              mark_valid
);
    localparam int STAGES = MAX_DLY + 1;

    logic [DLY_W-1:0] dly_q;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic             spy_run;
    logic [SPY_W-1:0] cap_data;

    // Hold the host-written delay setting.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dly_q <= '0;
        else if (dly_we)
            dly_q <= dly_wdata;
    end

    tas_delay_line #(.DATA_W(DATA_W), .DEPTH(STAGES), .SEL_W(DLY_W)) u_dly (
        .clk(clk), .rst_n(rst_n), .din(in_word), .sel(dly_q), .dout(out_word)
    );

    tas_spy_ctrl #(.DEPTH(SPY_DEPTH), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .arm(arm), .wr_en(wr_en), .wr_idx(wr_idx),
        .running(spy_run), .done(spy_done)
    );

    generate
        if (FULL_SPY != 0) begin : g_full
            assign cap_data = out_word;
        end else begin : g_lite
            assign cap_data = out_word[MARK_BIT];
        end
    endgenerate

    tas_spy_mem #(.W(SPY_W), .DEPTH(SPY_DEPTH), .IDX_W(IDX_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(cap_data), .rd_idx(rd_addr), .rd_data(rd_data)
    );

    tas_marker_track #(.IDX_W(IDX_W)) u_mark (
        .clk(clk), .rst_n(rst_n), .clr(arm), .hit(wr_en && out_word[MARK_BIT]),
        .idx(wr_idx), .done(spy_done), .first_idx(mark_pos), .single(mark_valid)
    );
endmodule

// File: rtl/tick_align_spy_chk.sv
// Property checker for tick_align_spy, attached by bind.
// Assumes: it watches ports and two internal signals only.
module tick_align_spy_chk #(
    parameter int DATA_W = 8,
    parameter int DLY_W  = 2,
    parameter int IDX_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arm,
    input logic [DATA_W-1:0] in_word,
    input logic [DATA_W-1:0] out_word,
    input logic [DLY_W-1:0]  dly_q,
    input logic              spy_run,
    input logic              spy_done,
    input logic [IDX_W-1:0]  mark_pos,
    input logic              mark_valid
);
    logic warm;

    // Note that the previous edge was outside reset, so the shift stages hold real input.
    always_ff @(posedge clk) begin
        warm <= rst_n;
    end

    AST_ZERO_DELAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (warm === 1'b1 && dly_q == '0) |-> out_word == $past(in_word)); // R2
    AST_ARM_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> !spy_done); // R5
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (spy_done && !arm) |=> spy_done); // R5
    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spy_done) |-> $past(spy_run)); // R4
    AST_VALID_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        mark_valid |-> spy_done); // R7
    AST_POS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (spy_done && !arm) |=> $stable(mark_pos)); // R10
endmodule

bind tick_align_spy tick_align_spy_chk #(.DATA_W(DATA_W), .DLY_W(DLY_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .arm(arm), .in_word(in_word), .out_word(out_word),
    .dly_q(dly_q), .spy_run(spy_run), .spy_done(spy_done),
    .mark_pos(mark_pos), .mark_valid(mark_valid)
);

// File: tb/tick_align_spy_test.sv
// Bench: behavioural reference model compared against the design on every clock.
module tick_align_spy_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_word = '0;
    logic       dly_we = 1'b0;
    logic [1:0] dly_wdata = '0;
    logic       arm = 1'b0;
    logic [2:0] rd_addr = '0;
    logic [7:0] out_word;
    logic [7:0] rd_data;
    logic       spy_done, mark_valid;
    logic [2:0] mark_pos;
    logic [7:0] lite_out;
    logic [0:0] lite_rd;
    logic       lite_done, lite_valid;
    logic [2:0] lite_pos;

    always #4 clk = ~clk;

    tick_align_spy uut (
        .clk(clk), .rst_n(rst_n), .in_word(in_word), .dly_we(dly_we), .dly_wdata(dly_wdata),
        .arm(arm), .rd_addr(rd_addr), .out_word(out_word), .rd_data(rd_data),
        .spy_done(spy_done), .mark_pos(mark_pos), .mark_valid(mark_valid)
    );

    tick_align_spy #(.FULL_SPY(0)) uut_lite (
        .clk(clk), .rst_n(rst_n), .in_word(in_word), .dly_we(dly_we), .dly_wdata(dly_wdata),
        .arm(arm), .rd_addr(rd_addr), .out_word(lite_out), .rd_data(lite_rd),
        .spy_done(lite_done), .mark_pos(lite_pos), .mark_valid(lite_valid)
    );

    int checks = 0;
    int fails  = 0;
    int tcnt   = 0;
    string t_out = "R2", t_rd = "R9", t_val = "R7";

    // reference model state
    int hist[$] = '{0, 0, 0, 0};
    int spy_m[8];
    int dly_m = 0, rd_m = 0, lite_m = 0;
    bit run_m = 0, done_m = 0;
    int idx_m = 0, mcnt_m = 0, mpos_m = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at tick %0d", tag, act, exp, tcnt);
        end
    endtask

    function automatic logic [7:0] pat(input int k);
        if (k % 8 == 7) return 8'h13;
        return (k % 2 == 0) ? 8'h01 : 8'h02;
    endfunction

    // One cycle: compare at the falling edge, drive inputs, advance the model across the next rising edge.
    task automatic tick(input logic [7:0] d, input bit a, input bit we, input int wd, input bit rst_i);
        bit v;
        int cur;
        @(negedge clk);
        if (rst_i || !rst_n) begin
            chk("R1 out_word", out_word, hist[dly_m]);
            chk("R1 spy_done", spy_done, 0);
            chk("R1 mark_valid", mark_valid, 0);
            chk("R1 rd_data", rd_data, 0);
        end else begin
            chk({t_out, " out_word"}, out_word, hist[dly_m]);
            chk("R5 spy_done", spy_done, done_m);
            v = done_m && (mcnt_m == 1);
            chk({t_val, " mark_valid"}, mark_valid, v);
            if (v) chk({t_val, " mark_pos"}, mark_pos, mpos_m);
            chk({t_rd, " rd_data"}, rd_data, rd_m);
            chk("R6 lite rd_data", lite_rd, lite_m);
        end
        rst_n     = !rst_i;
        in_word   = d;
        arm       = a;
        dly_we    = we;
        dly_wdata = wd[1:0];
        rd_addr   = tcnt[2:0];
        if (rst_i) begin
            hist = '{0, 0, 0, 0};
            foreach (spy_m[i]) spy_m[i] = 0;
            dly_m = 0; rd_m = 0; lite_m = 0; run_m = 0; done_m = 0;
            idx_m = 0; mcnt_m = 0; mpos_m = 0;
        end else begin
            cur    = hist[dly_m];
            rd_m   = spy_m[tcnt % 8];
            lite_m = (spy_m[tcnt % 8] >> 4) & 1;
            if (a) begin
                run_m = 1; idx_m = 0; done_m = 0; mcnt_m = 0; mpos_m = 0;
            end else if (run_m) begin
                spy_m[idx_m] = cur;
                if (((cur >> 4) & 1) == 1) begin
                    if (mcnt_m == 0) mpos_m = idx_m;
                    if (mcnt_m < 2) mcnt_m++;
                end
                if (idx_m == 7) begin run_m = 0; done_m = 1; end
                idx_m++;
            end
            if (we) dly_m = wd;
            hist.push_front(int'(d));
            void'(hist.pop_back());
        end
        tcnt++;
    endtask

    task automatic run_pat(input int n, input logic [7:0] andm, input logic [7:0] orm);
        for (int i = 0; i < n; i++) tick((pat(tcnt) & andm) | orm, 0, 0, 0, 0);
    endtask

    task automatic capture(input logic [7:0] andm, input logic [7:0] orm);
        tick((pat(tcnt) & andm) | orm, 1, 0, 0, 0);
        run_pat(20, andm, orm);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) tick(8'h5a, 0, 0, 0, 1);
        t_rd = "R9"; t_val = "R7";
        run_pat(12, 8'hff, 8'h00);
        capture(8'hff, 8'h00);                           // R4 capture, dly 0
        t_out = "R3"; tick(pat(tcnt), 0, 1, 2, 0); run_pat(6, 8'hff, 8'h00); t_out = "R2";
        capture(8'hff, 8'h00);                           // R7 marker shifted by delay 2
        t_out = "R3"; tick(pat(tcnt), 0, 1, 3, 0); run_pat(6, 8'hff, 8'h00); t_out = "R2";
        capture(8'hff, 8'h00);
        t_out = "R3"; tick(pat(tcnt), 0, 1, 1, 0); run_pat(6, 8'hff, 8'h00); t_out = "R2";
        capture(8'hff, 8'h00);
        t_val = "R8";
        capture(8'hef, 8'h00);                           // R8 no marker
        capture(8'hff, 8'h00);
        for (int i = 0; i < 24; i++)                      // R8 two markers per period
            tick(pat(tcnt) | ((tcnt % 4 == 0) ? 8'h10 : 8'h00), (i == 0), 0, 0, 0);
        t_val = "R7"; t_rd = "R10";
        run_pat(24, 8'h00, 8'h1f);                        // R10 buffer must hold after done
        t_rd = "R11"; t_val = "R11";
        tick(8'h13, 1, 0, 0, 0);
        run_pat(3, 8'hff, 8'h00);
        tick(pat(tcnt), 1, 0, 0, 0);                      // R11 restart mid-capture
        run_pat(20, 8'hff, 8'h00);
        t_rd = "R9";
        tick(pat(tcnt), 1, 1, 0, 0);
        run_pat(20, 8'hff, 8'h00);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=<200000 cycles", tcnt);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule